// File: doc/BRIEF.md
# Pipelined Converter Timing Model

This block is a cycle-based behavioural model of a sampling data converter's output timing. Everything is counted in cycles of a fast system clock. A separate convert-clock input is watched for rising edges. Each rising edge that is far enough from the previous accepted one starts a conversion. On that same system-clock edge, a signed fixed-point sample, standing in for the analog level, is captured and quantized to a `DATA_W`-bit code.

Each code is driven onto the data output exactly `LATENCY` cycles after its start edge. Several conversions can be in flight at once. Every time a result lands, the data-valid output drops low for `VALID_LOW` cycles.

A convert-clock edge that comes too soon after the last accepted start is dropped without a trace. A build whose minimum spacing `MIN_GAP` is not below `LATENCY` is rejected at elaboration.

Top module: `adc_pipe_timing`

## Requirements
- R1: While and right after reset, `data_out` is all zeros, `data_valid` is 1 and no conversion is pending.
- R2: A start edge is a system-clock edge where `conv_clk` is 1 and was 0 at the previous system-clock edge. The converted value is `sample_in` as seen on that edge; later changes of `sample_in` do not alter that conversion's result.
- R3: The result of a conversion appears on `data_out` on the system-clock edge exactly `LATENCY` cycles after its start edge.
- R4: On the edge where a result lands, `data_valid` goes to 0. It returns to 1 `VALID_LOW` cycles later if no further result lands.
- R5: A start edge is accepted only if more than `MIN_GAP` cycles have passed since the previous accepted start. A spacing of exactly `MIN_GAP` is dropped; `MIN_GAP+1` is accepted. The first start edge after reset is always accepted.
- R6: A dropped start edge produces no result. `data_out` changes only on an edge where a result lands.
- R7: Conversions overlap freely within the spacing rule, and their results land in start order.
- R8: The two's-complement code is floor((sample_in - OFFSET) * 2^DATA_W / 2^RANGE_LOG2), saturated to the range -2^(DATA_W-1) to 2^(DATA_W-1)-1.
- R9: With `CODING = CODE_OFFSET_BIN`, the output is the two's-complement code with its most significant bit inverted. With `CODE_TWOS`, the output is the two's-complement code itself.
- R10: If a result lands while `data_valid` is already 0, the low period restarts from that landing and lasts a further `VALID_LOW` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk | input | 1 | Convert clock; its rising edges request conversions |
| sample_in | input | IN_W | Signed fixed-point input level |
| data_out | output | DATA_W | Registered conversion code |
| data_valid | output | 1 | Registered strobe; low for a while after each landing |

## Verification
The hardest situation to reach from the ports is a landing that falls inside the low window of an earlier landing, while another conversion is still in flight behind it.

The stimulus reaches it by running the bench build with `VALID_LOW` longer than the minimum accepted spacing. It then fires a train of starts at exactly `MIN_GAP+1` cycles, so three conversions overlap and each landing restarts the low window. Right before that train, a start at exactly `MIN_GAP` spacing is placed, so the drop boundary is exercised in the same pass.

A second instance uses the other coding and a non-zero offset on the same stimulus, so both quantization paths are compared together.

// File: rtl/adc_timing_pkg.sv
package adc_timing_pkg;
  typedef enum logic {
    CODE_OFFSET_BIN = 1'b0,
    CODE_TWOS       = 1'b1
  } code_fmt_e;
endpackage

// File: rtl/adc_start_gate.sv
module adc_start_gate #(
  parameter int MIN_GAP = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_clk,
  output logic start
);
  localparam int GW = $clog2(MIN_GAP + 2);
  localparam logic [GW-1:0] ARMED = GW'(MIN_GAP + 1);

  logic          conv_q;
  logic [GW-1:0] since;

  assign start = conv_clk && !conv_q && (since > GW'(MIN_GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_q <= 1'b0;
      since  <= ARMED;
    end else begin
      conv_q <= conv_clk;
      if (start)
        since <= GW'(1);
      else if (since != ARMED)
        since <= since + GW'(1);
    end
  end

  // Two accepted starts are never on adjacent edges (MIN_GAP >= 1).
  AST_START_SPACED: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);  // R5
endmodule

// File: rtl/adc_quantizer.sv
module adc_quantizer
  import adc_timing_pkg::*;
#(
  parameter int        IN_W       = 16,
  parameter int        DATA_W     = 8,
  parameter int        RANGE_LOG2 = 16,
  parameter int        OFFSET     = 0,
  parameter code_fmt_e CODING     = CODE_OFFSET_BIN
) (
  input  logic signed [IN_W-1:0]   sample,
  output logic        [DATA_W-1:0] code
);
  localparam int WW = IN_W + DATA_W + 2;
  localparam logic signed [WW-1:0] CMAX = (WW'(1) << (DATA_W - 1)) - WW'(1);
  localparam logic signed [WW-1:0] CMIN = ~CMAX;
  localparam logic [DATA_W-1:0]    MSB  = DATA_W'(1) << (DATA_W - 1);

  logic signed [WW-1:0]   diff, scaled, clamped;
  logic        [DATA_W-1:0] tc;

  assign diff = WW'(sample) - WW'(OFFSET);

  generate
    if (RANGE_LOG2 >= DATA_W) begin : g_shr
      assign scaled = diff >>> (RANGE_LOG2 - DATA_W);
    end else begin : g_shl
      assign scaled = diff <<< (DATA_W - RANGE_LOG2);
    end
  endgenerate

  always_comb begin
    if (scaled > CMAX)      clamped = CMAX;
    else if (scaled < CMIN) clamped = CMIN;
    else                    clamped = scaled;
  end

  assign tc = clamped[DATA_W-1:0];

  generate
    if (CODING == CODE_TWOS) begin : g_twos
      assign code = tc;
    end else begin : g_obin
      assign code = tc ^ MSB;
    end
  endgenerate
endmodule

// File: rtl/adc_flight_fifo.sv
module adc_flight_fifo #(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 20,
  parameter int MIN_GAP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] code_in,
  output logic              pop,
  output logic [DATA_W-1:0] code_out
);
  localparam int DEPTH_MIN = (LATENCY + MIN_GAP - 1) / MIN_GAP + 1;
  localparam int AW        = (DEPTH_MIN > 1) ? $clog2(DEPTH_MIN) : 1;
  localparam int PDEPTH    = 1 << AW;
  localparam int TW        = $clog2(LATENCY + 1) + 1;

  logic [DATA_W-1:0] mem_code [PDEPTH];
  logic [TW-1:0]     mem_due  [PDEPTH];
  logic [AW-1:0]     wp, rp;
  logic [AW:0]       count;
  logic [TW-1:0]     now;

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (push) begin
      mem_code[wp] <= code_in;
      mem_due[wp]  <= now + TW'(LATENCY);
    end
  end

  assign pop      = (count != '0) && (mem_due[rp] == now);
  assign code_out = mem_code[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      now   <= '0;
    end else begin
      now <= now + TW'(1);
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < (AW+1)'(PDEPTH)) || pop);  // R7
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    rst |=> (count == '0));  // R1
endmodule

// File: rtl/adc_valid_strobe.sv
module adc_valid_strobe #(
  parameter int VALID_LOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic land,
  output logic data_valid
);
  localparam int CW = $clog2(VALID_LOW + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_valid <= 1'b1;
      left       <= '0;
    end else if (land) begin
      data_valid <= 1'b0;
      left       <= CW'(VALID_LOW - 1);
    end else if (!data_valid) begin
      if (left == '0) data_valid <= 1'b1;
      else            left       <= left - CW'(1);
    end
  end

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    land |=> !data_valid);  // R4
  AST_VALID_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (!data_valid && land) |=> (!data_valid && left == CW'(VALID_LOW - 1)));  // R10
endmodule

// File: rtl/adc_pipe_timing.sv
module adc_pipe_timing
  import adc_timing_pkg::*;
#(
  parameter int        IN_W       = 16,
  parameter int        DATA_W     = 8,
  parameter int        RANGE_LOG2 = 16,
  parameter int        OFFSET     = 0,
  parameter code_fmt_e CODING     = CODE_OFFSET_BIN,
  parameter int        LATENCY    = 20,
  parameter int        MIN_GAP    = 6,
  parameter int        VALID_LOW  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   conv_clk,
  input  logic signed [IN_W-1:0] sample_in,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_valid
);
  generate
    if (MIN_GAP >= LATENCY || MIN_GAP < 1 || DATA_W < 1 || DATA_W > 32
        || VALID_LOW < 1) begin : g_illegal_cfg
      $error("adc_pipe_timing: MIN_GAP must be in 1..LATENCY-1, DATA_W in 1..32");
    end
  endgenerate

  logic              start, land;
  logic [DATA_W-1:0] new_code, head_code;

  adc_start_gate #(.MIN_GAP(MIN_GAP)) u_gate (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .start(start)
  );

  adc_quantizer #(
    .IN_W(IN_W), .DATA_W(DATA_W), .RANGE_LOG2(RANGE_LOG2),
    .OFFSET(OFFSET), .CODING(CODING)
  ) u_quant (
    .sample(sample_in), .code(new_code)
  );

  adc_flight_fifo #(
    .DATA_W(DATA_W), .LATENCY(LATENCY), .MIN_GAP(MIN_GAP)
  ) u_fifo (
    .clk(clk), .rst(rst), .push(start), .code_in(new_code),
    .pop(land), .code_out(head_code)
  );

  adc_valid_strobe #(.VALID_LOW(VALID_LOW)) u_strobe (
    .clk(clk), .rst(rst), .land(land), .data_valid(data_valid)
  );

  always_ff @(posedge clk) begin
    if (rst)       data_out <= '0;
    else if (land) data_out <= head_code;
  end

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !land |=> $stable(data_out));  // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (data_out == '0 && data_valid));  // R1
endmodule

// File: tb/adc_pipe_timing_test.sv
`timescale 1ns/1ps
module adc_pipe_timing_test;
  import adc_timing_pkg::*;

  localparam int LAT   = 20;
  localparam int GAP   = 6;
  localparam int VLOW  = 10;
  localparam int DW    = 8;
  localparam int IW    = 16;
  localparam int RL    = 16;
  localparam int OFF_B = -300;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 conv_clk = 1'b0;
  logic signed [IW-1:0] ain = '0;
  logic [DW-1:0]        dout_a, dout_b;
  logic                 dv_a, dv_b;

  always #2.5 clk = ~clk;

  adc_pipe_timing #(
    .IN_W(IW), .DATA_W(DW), .RANGE_LOG2(RL), .OFFSET(0),
    .CODING(CODE_OFFSET_BIN), .LATENCY(LAT), .MIN_GAP(GAP), .VALID_LOW(VLOW)
  ) uut (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .sample_in(ain),
    .data_out(dout_a), .data_valid(dv_a)
  );

  adc_pipe_timing #(
    .IN_W(IW), .DATA_W(DW), .RANGE_LOG2(RL), .OFFSET(OFF_B),
    .CODING(CODE_TWOS), .LATENCY(LAT), .MIN_GAP(GAP), .VALID_LOW(VLOW)
  ) uut2 (
    .clk(clk), .rst(rst), .conv_clk(conv_clk), .sample_in(ain),
    .data_out(dout_b), .data_valid(dv_b)
  );

  typedef struct {
    int           due;
    logic [DW-1:0] ca;
    logic [DW-1:0] cb;
  } exp_t;

  exp_t          sb[$];
  int            cyc = 0;
  int            last_acc = -1000;
  int            last_land = -1000;
  logic [DW-1:0] exp_a = '0, exp_b = '0;
  int            vectors = 0, miscompares = 0;
  bit            mon_on = 0, done = 0, retrig = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Expected code from R8 and R9.
  function automatic logic [DW-1:0] model(int v, int off, bit twos);
    longint d  = longint'(v) - longint'(off);
    longint s  = d >>> (RL - DW);
    longint hi = (longint'(1) <<< (DW - 1)) - 1;
    longint lo = -(longint'(1) <<< (DW - 1));
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    if (twos) return DW'(s);
    return DW'(s - lo);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // Driver: one convert-clock pulse, next pulse 'span' cycles later.
  task automatic start_conv(int v, int span);
    int edge_c;
    @(negedge clk);
    edge_c   = cyc + 1;
    conv_clk = 1'b1;
    ain      = IW'(v);
    if (edge_c - last_acc > GAP) begin  // R5 spacing rule
      sb.push_back('{due: edge_c + LAT, ca: model(v, 0, 0), cb: model(v, OFF_B, 1)});
      last_acc = edge_c;
    end
    @(negedge clk);
    conv_clk = 1'b0;
    ain      = IW'($urandom_range(0, 65535));  // R2: later input must not leak
    repeat (span - 2) @(negedge clk);
  endtask

  // Monitor: pops expected results at their due cycle and compares.
  always @(negedge clk) begin
    if (mon_on) begin
      bit landed = 0;
      retrig = 0;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        if (cyc - last_land < VLOW) retrig = 1;
        exp_a     = sb[0].ca;
        exp_b     = sb[0].cb;
        last_land = cyc;
        void'(sb.pop_front());
        landed = 1;
      end
      if (landed) begin
        check("R2 R3 R7 R8 R9 offset-binary data", dout_a, exp_a);
        check("R2 R3 R7 R8 R9 twos data", dout_b, exp_b);
      end else begin
        check("R5 R6 data held", dout_a, exp_a);
        check("R5 R6 data held", dout_b, exp_b);
      end
      if (retrig || (cyc - last_land < VLOW && cyc - last_land > 0 && last_land > 0 && 0)) begin
        check("R10 valid retrigger", dv_a, 0);
      end
      check((cyc - last_land < VLOW) ? "R4 R10 valid low" : "R4 valid high",
            dv_a, (cyc - last_land < VLOW) ? 0 : 1);
      check("R4 valid second instance", dv_b, dv_a);
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset data", dout_a, 0);
    check("R1 reset data", dout_b, 0);
    check("R1 reset valid", dv_a, 1);
    check("R1 reset valid", dv_b, 1);
    rst    = 1'b0;
    mon_on = 1;

    // First start after reset is accepted (R5), single conversion (R3).
    start_conv(1000, 30);
    // Exactly GAP spacing is dropped; GAP+1 accepted (R5, R6).
    start_conv(-1000, GAP);
    start_conv(500, GAP + 1);
    // Overlapping train at the minimum legal spacing (R7, R10).
    start_conv(700, GAP + 1);
    start_conv(800, GAP + 1);
    start_conv(900, 40);
    // Saturation and coding corners (R8, R9).
    start_conv(32767, 25);
    start_conv(-32768, 25);
    start_conv(0, 25);
    start_conv(-1, 25);
    start_conv(255, 25);
    // Mixed spacing, some dropped.
    for (int i = 0; i < 60; i++)
      start_conv(int'($urandom_range(0, 65535)) - 32768, 2 + int'($urandom_range(0, 10)));
    repeat (LAT + VLOW + 5) @(negedge clk);
    check("R7 all results landed", sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R3 watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule